// File: doc/BRIEF.md
# Transmit Frame Padder and FCS Appender

This block sits on the byte-wide transmit path of an Ethernet MAC, between the client's frame stream and the preamble and PHY stages. Frames enter one byte per transfer, with start and end flags on a valid/ready handshake. If padding is switched on, any frame that ends before reaching the minimum header-plus-payload length of 60 bytes gets zero bytes added until it reaches exactly 60. If CRC insertion is switched on, the block computes the Ethernet CRC-32 over every byte it emits, pad bytes included. It then appends the result as a four-byte frame check sequence, so a minimal frame leaves the block at 64 bytes.

Two small control registers switch the two features on and off independently. The setting that applies to a frame is the one in the registers when the frame's first byte is accepted, so software may write at any time without damaging a frame in flight. While pad or check bytes are being emitted, the block drops its upstream ready signal. The client therefore holds its next byte and nothing is lost.

Top module: `tx_pad_fcs`

## Requirements
- R1: After reset, register 0 (padding control) reads 0x00000001 and register 1 (checksum control) reads 0x00000003, meaning padding and CRC insertion are both on.
- R2: In register 0 only bit 0 (pad enable) is writable. In register 1 only bit 1 (CRC insert enable) is writable, and bit 0 always reads 1. Every other bit reads 0 whatever value is written.
- R3: With padding on, a frame whose input length is below 60 bytes leaves the block with exactly 60 data bytes. The first bytes are the input bytes in order and the added bytes are 0x00.
- R4: A frame of 60 bytes or more is never padded. Its data bytes leave the block unchanged and in order.
- R5: With padding off, a frame leaves the block with the same number of data bytes it entered with, whatever its length.
- R6: With CRC insertion on, four check bytes follow the data. They are the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones, result inverted) taken over all emitted data bytes including pad bytes, and they are sent least significant byte first.
- R7: With CRC insertion off, no check bytes are appended. The end flag sits on the last data or pad byte.
- R8: While pad or check bytes are being emitted, upstream ready is low and output valid is high. A following frame offered back to back is accepted intact after the current frame ends.
- R9: A register write made while a frame is in progress does not affect that frame. It applies from the next frame's first byte.
- R10: Each output frame carries the start flag on its first byte only and the end flag on its final byte only. A one-byte input frame, with start and end on the same byte, is handled like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 padding control, 1 checksum control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the register selected by cfg_addr |
| in_data | input | 8 | Frame byte from the client |
| in_valid | input | 1 | Client byte valid |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_ready | output | 1 | Block accepts the client byte this cycle |
| out_data | output | 8 | Emitted frame byte |
| out_valid | output | 1 | Emitted byte valid |
| out_sop | output | 1 | First emitted byte of a frame |
| out_eop | output | 1 | Last emitted byte of a frame |
| out_ready | input | 1 | Downstream accepts the emitted byte |

## Verification
Two events that can land in the same cycle matter here. The first is a register write arriving while a frame is in flight, including the cycles around its first-byte acceptance. The bench provokes this by writing both registers a few bytes into a padded frame. The old setting must shape that frame and the new setting the next one. The second is a frame's end coinciding with the client already presenting the next frame's start byte. Back-to-back frames under pseudo-random downstream backpressure provoke this, and the bench checks that the concatenated output matches the two expected frames byte for byte with their flags.

// File: rtl/tx_pf_pkg.sv
package tx_pf_pkg;

  localparam int          REG_W         = 32;
  localparam int          FCS_BYTES     = 4;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_PAD  = 2'd1,
    PH_FCS  = 2'd2
  } phase_e;

  // one byte of the reflected CRC-32, bit 0 of the byte first
  function automatic logic [31:0] crc32_step(input logic [31:0] c,
                                             input logic [7:0]  d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/tx_pf_regs.sv
module tx_pf_regs
  import tx_pf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             pad_en,
  output logic             crc_en
);

  logic pad_q;
  logic crc_q;
  logic unused_wbits;

  assign unused_wbits = ^cfg_wdata[REG_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= 1'b1;
      crc_q <= 1'b1;
    end else if (cfg_we) begin
      if (cfg_addr) crc_q <= cfg_wdata[1];
      else          pad_q <= cfg_wdata[0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr) begin
      cfg_rdata[0] = 1'b1;
      cfg_rdata[1] = crc_q;
    end else begin
      cfg_rdata[0] = pad_q;
    end
  end

  assign pad_en = pad_q;
  assign crc_en = crc_q;

  // R2
  wrhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(pad_q) && $stable(crc_q)));

endmodule

// File: rtl/tx_pf_crc.sv
module tx_pf_crc
  import tx_pf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  logic        restart,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);

  logic [31:0] crc_q;
  logic [31:0] crc_base;

  assign crc_base = restart ? CRC_PRESET : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= CRC_PRESET;
    else if (upd) crc_q <= crc32_step(crc_base, din);
  end

  assign fcs = ~crc_q;

  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(crc_q));

endmodule

// File: rtl/tx_pf_ctrl.sv
module tx_pf_ctrl
  import tx_pf_pkg::*;
#(
  parameter int MIN_LEN = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pad_reg,
  input  logic        crc_reg,
  input  logic [31:0] fcs,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic        in_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_eop,
  input  logic        out_ready,
  output logic        crc_upd,
  output logic        crc_restart
);

  localparam int CW    = $clog2(MIN_LEN + 1);
  localparam int IW    = $clog2(FCS_BYTES);
  localparam int LASTB = FCS_BYTES - 1;

  typedef logic [CW-1:0] cnt_t;

  function automatic cnt_t len_inc(input cnt_t c);
    return (c >= cnt_t'(MIN_LEN)) ? c : c + cnt_t'(1);
  endfunction

  phase_e         ph_q;
  cnt_t           cnt_q;
  logic [IW-1:0]  idx_q;
  logic           in_frame;
  logic           pad_sh;
  logic           crc_sh;

  logic           pad_eff;
  logic           crc_eff;
  cnt_t           len_now;
  logic           pad_more;
  logic           pad_last;
  logic           fcs_last;
  logic           xfer;
  logic           sop_xfer;
  logic           ext_active;

  assign pad_eff    = in_frame ? pad_sh : pad_reg;
  assign crc_eff    = in_frame ? crc_sh : crc_reg;
  assign len_now    = in_sop ? cnt_t'(1) : len_inc(cnt_q);
  assign pad_more   = pad_eff && (len_now < cnt_t'(MIN_LEN));
  assign pad_last   = (cnt_q == cnt_t'(MIN_LEN - 1));
  assign fcs_last   = (idx_q == IW'(LASTB));
  assign ext_active = (ph_q != PH_DATA);

  always_comb begin
    out_data  = in_data;
    out_valid = in_valid;
    out_sop   = in_sop;
    out_eop   = 1'b0;
    in_ready  = out_ready;
    case (ph_q)
      PH_PAD: begin
        out_data  = 8'h00;
        out_valid = 1'b1;
        out_sop   = 1'b0;
        out_eop   = !crc_eff && pad_last;
        in_ready  = 1'b0;
      end
      PH_FCS: begin
        out_data  = fcs[8*idx_q +: 8];
        out_valid = 1'b1;
        out_sop   = 1'b0;
        out_eop   = fcs_last;
        in_ready  = 1'b0;
      end
      default: begin
        out_eop = in_eop && !pad_more && !crc_eff;
      end
    endcase
  end

  assign xfer        = out_valid && out_ready;
  assign sop_xfer    = xfer && (ph_q == PH_DATA) && in_sop;
  assign crc_upd     = xfer && (ph_q != PH_FCS);
  assign crc_restart = (ph_q == PH_DATA) && in_sop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_DATA;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (xfer) begin
      case (ph_q)
        PH_DATA: begin
          cnt_q <= len_now;
          if (in_eop) begin
            if (pad_more)     ph_q <= PH_PAD;
            else if (crc_eff) ph_q <= PH_FCS;
          end
        end
        PH_PAD: begin
          cnt_q <= cnt_q + cnt_t'(1);
          if (pad_last) ph_q <= crc_eff ? PH_FCS : PH_DATA;
        end
        PH_FCS: begin
          idx_q <= idx_q + IW'(1);
          if (fcs_last) begin
            idx_q <= '0;
            ph_q  <= PH_DATA;
          end
        end
        default: ph_q <= PH_DATA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      pad_sh   <= 1'b1;
      crc_sh   <= 1'b1;
    end else begin
      if (sop_xfer) begin
        pad_sh <= pad_reg;
        crc_sh <= crc_reg;
      end
      if (xfer && out_eop)  in_frame <= 1'b0;
      else if (sop_xfer)    in_frame <= 1'b1;
    end
  end

  // R8
  ext_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_active |-> !in_ready);

  // R8
  ext_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_active |-> out_valid);

  // R3
  pad_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PAD) |-> (cnt_q < cnt_t'(MIN_LEN)));

  // R6
  fcs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_FCS && xfer && fcs_last) |=> (ph_q == PH_DATA && !in_frame));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !sop_xfer) |=> ($stable(pad_sh) && $stable(crc_sh)));

endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
  import tx_pf_pkg::*;
#(
  parameter int MIN_LEN = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic        in_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_eop,
  input  logic        out_ready
);

  logic        pad_en;
  logic        crc_en;
  logic        crc_upd;
  logic        crc_restart;
  logic [31:0] fcs;

  tx_pf_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pad_en    (pad_en),
    .crc_en    (crc_en)
  );

  tx_pf_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (crc_upd),
    .restart (crc_restart),
    .din     (out_data),
    .fcs     (fcs)
  );

  tx_pf_ctrl #(.MIN_LEN(MIN_LEN)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pad_reg     (pad_en),
    .crc_reg     (crc_en),
    .fcs         (fcs),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_sop      (in_sop),
    .in_eop      (in_eop),
    .in_ready    (in_ready),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_ready   (out_ready),
    .crc_upd     (crc_upd),
    .crc_restart (crc_restart)
  );

endmodule

// File: tb/tb_tx_pad_fcs.sv
module tb_tx_pad_fcs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_sop;
  logic        out_eop;
  logic        out_ready = 1'b1;

  int tests = 0;
  int fails = 0;

  logic [7:0] exp_b [0:511];
  logic [1:0] exp_f [0:511];
  int         exp_n = 0;
  logic [7:0] rx_b  [0:511];
  logic [1:0] rx_f  [0:511];
  int         rx_n  = 0;

  logic       bp_on = 1'b0;
  logic [7:0] lfsr  = 8'hA5;

  always #10 clk = ~clk;

  tx_pad_fcs dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_data(in_data),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_ready(out_ready)
  );

  initial forever begin
    @(negedge clk);
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  initial forever begin
    @(negedge clk);
    #5;
    if (rst_n && out_valid && out_ready && rx_n < 512) begin
      rx_b[rx_n] = out_data;
      rx_f[rx_n] = {out_sop, out_eop};
      rx_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual hang, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [7:0] byte_of(input int len, input int i);
    return 8'((len * 13 + i * 7 + 1) & 255);
  endfunction

  // CRC kept in the non-reflected (MSB-first) form, reflected at the end
  function automatic logic [31:0] ref_crc_step(input logic [31:0] r, input logic [7:0] d);
    logic [31:0] x;
    x = r;
    for (int b = 0; b < 8; b++) begin
      if (x[31] ^ d[b]) x = (x << 1) ^ 32'h04C11DB7;
      else              x = x << 1;
    end
    return x;
  endfunction

  function automatic logic [31:0] bitrev32(input logic [31:0] v);
    logic [31:0] o;
    for (int k = 0; k < 32; k++) o[k] = v[31-k];
    return o;
  endfunction

  task automatic add_expected(input int len, input bit pad, input bit crc);
    int          n;
    int          start;
    logic [31:0] r;
    logic [31:0] f;
    start = exp_n;
    n = (pad && len < 60) ? 60 : len;
    r = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      exp_b[exp_n] = (i < len) ? byte_of(len, i) : 8'h00;
      exp_f[exp_n] = 2'b00;
      r = ref_crc_step(r, exp_b[exp_n]);
      exp_n++;
    end
    if (crc) begin
      f = ~bitrev32(r);
      for (int k = 0; k < 4; k++) begin
        exp_b[exp_n] = f[8*k +: 8];
        exp_f[exp_n] = 2'b00;
        exp_n++;
      end
    end
    exp_f[start]     = exp_f[start] | 2'b10;
    exp_f[exp_n - 1] = exp_f[exp_n - 1] | 2'b01;
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = byte_of(len, i);
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      #5;
      while (!in_ready) begin
        @(negedge clk);
        #5;
      end
    end
  endtask

  task automatic idle_input();
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic check_stream(input string tag);
    int  guard;
    int  bad;
    guard = 0;
    while (rx_n < exp_n && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
    tests++;
    bad = -1;
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && (i >= rx_n || rx_b[i] !== exp_b[i] || rx_f[i] !== exp_f[i])) bad = i;
    if (rx_n != exp_n) begin
      fails++;
      $display("FAIL %s R10: byte count actual %0d expected %0d", tag, rx_n, exp_n);
    end else if (bad >= 0) begin
      fails++;
      $display("FAIL %s R10: byte %0d actual %02h/%b expected %02h/%b",
               tag, bad, rx_b[bad], rx_f[bad], exp_b[bad], exp_f[bad]);
    end
    rx_n  = 0;
    exp_n = 0;
  endtask

  task automatic reg_write(input logic a, input logic [31:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic reg_check(input logic a, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #5;
    tests++;
    if (cfg_rdata !== e) begin
      fails++;
      $display("FAIL %s: reg %0d actual %08h expected %08h", tag, a, cfg_rdata, e);
    end
  endtask

  task automatic set_cfg(input bit pad, input bit crc);
    reg_write(1'b0, {31'd0, pad});
    reg_write(1'b1, {30'd0, crc, 1'b1});
  endtask

  task automatic one_frame(input int len, input bit pad, input bit crc, input string tag);
    add_expected(len, pad, crc);
    send_frame(len);
    idle_input();
    check_stream(tag);
  endtask

  int lens [6] = '{1, 2, 59, 60, 61, 64};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values and idle outputs
    reg_check(1'b0, 32'h1, "R1 pad reset");
    reg_check(1'b1, 32'h3, "R1 crc reset");
    @(negedge clk); #5;
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle out_valid actual %b expected 0", out_valid);
    end

    // R2: reserved bits and the fixed bit
    reg_write(1'b0, 32'hFFFF_FFFE);
    reg_check(1'b0, 32'h0, "R2 pad reserved");
    reg_write(1'b0, 32'hFFFF_FFFF);
    reg_check(1'b0, 32'h1, "R2 pad set");
    reg_write(1'b1, 32'h0);
    reg_check(1'b1, 32'h1, "R2 crc bit0 held");
    reg_write(1'b1, 32'hFFFF_FFFF);
    reg_check(1'b1, 32'h3, "R2 crc reserved");

    // R3 R4 R6: full length sweep with pad and CRC on
    for (int len = 1; len <= 70; len++) begin
      bp_on = len[0];
      one_frame(len, 1'b1, 1'b1, "R3 R4 R6 sweep");
    end

    // R5 R7: other configurations at the boundary lengths
    for (int c = 0; c < 3; c++) begin
      bit p;
      bit k;
      p = (c == 2);
      k = (c == 1);
      set_cfg(p, k);
      for (int j = 0; j < 6; j++) begin
        bp_on = j[0];
        one_frame(lens[j], p, k, "R3 R5 R6 R7 cfg");
      end
    end

    // R8: back-to-back frames, second waits during pad and FCS
    set_cfg(1'b1, 1'b1);
    bp_on = 1'b1;
    add_expected(5, 1'b1, 1'b1);
    add_expected(3, 1'b1, 1'b1);
    add_expected(62, 1'b1, 1'b1);
    send_frame(5);
    send_frame(3);
    send_frame(62);
    idle_input();
    check_stream("R8 back-to-back");
    bp_on = 1'b0;

    // R9: writes during a frame apply only to the next one
    add_expected(30, 1'b1, 1'b1);
    fork
      send_frame(30);
      begin
        repeat (6) @(negedge clk);
        reg_write(1'b0, 32'h0);
        reg_write(1'b1, 32'h1);
      end
    join
    idle_input();
    check_stream("R9 old cfg kept");
    one_frame(30, 1'b0, 1'b0, "R9 new cfg applied");

    // R10: single-byte frame with start and end together
    set_cfg(1'b0, 1'b1);
    one_frame(1, 1'b0, 1'b1, "R10 single byte");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule